// File: doc/BRIEF.md
# UART Register Front End

This block is the 32-bit register face of a simple serial port. A processor reaches it through a word-wide register port with a 32-byte address window. A write to the transmit slot sends one byte out on a strobed byte output. Bytes from the serial receiver arrive on a byte input with a valid/ready handshake. They wait in an eight-entry receive queue until software reads them out.

Four plain control words sit in the window: transmit control, receive control, interrupt enable and baud divisor. The block only stores them for the serial engines, which are outside this block. One level interrupt is raised while the receive interrupt is enabled and at least one byte is waiting. A pending word reports the same receive condition. There is no threshold and no transmit buffering.

Register slots, by byte offset: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 interrupt pending, 0x18 divisor. Offset 0x1C, and any offset whose two low bits are not zero, is unmapped. Read data appears on `bus_rdata` one clock after `bus_rd` and holds until the next read.

Top module: `uart_reg_front`

## Requirements
- R1: A synchronous active-high reset empties the receive queue and clears every control word, `bus_rdata`, `tx_byte`, `tx_strobe` and `irq` to zero; `rx_ready` is 1 after reset.
- R2: A write to offset 0x00 drives `tx_strobe` high for exactly the next cycle, with `tx_byte` equal to write data bits 7:0; `tx_strobe` is low at all other times, and a read of 0x00 returns 0.
- R3: A read of 0x04 while the queue holds bytes returns the oldest byte in bits 7:0 with bits 31:8 zero, and removes that byte; bytes leave in the order they arrived.
- R4: A read of 0x04 while the queue is empty returns 0x80000000 (bit 31 is the empty flag, data field zero) and changes nothing.
- R5: The queue holds at most 8 bytes; `rx_ready` is 1 exactly while it holds fewer than 8; a byte offered while `rx_ready` is 0 is discarded.
- R6: Offsets 0x08, 0x0C, 0x10 and 0x18 each store the full 32-bit written word and read it back unchanged.
- R7: Offset 0x14 reads 0x00000002 while the queue is non-empty and 0 when it is empty (bit 0, transmit pending, always 0); writes to it have no effect.
- R8: `irq` is 1 exactly when bit 1 of the interrupt enable word is set and the queue is non-empty, as seen one cycle after each push, pop or enable write; bit 0 of the enable word never raises `irq`.
- R9: Writes to unmapped offsets change no register and send no byte; reads of them return 0.
- R10: `bus_rdata` changes only in the cycle after a read and otherwise holds its last value.
- R11: A push and a pop in the same cycle both take effect: the read returns the queue's oldest byte, and the new byte joins the tail. When the queue is full at that edge, the new byte is still discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset inside the register window |
| bus_wr | input | 1 | Write enable, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable, one word per cycle |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_byte | input | 8 | Received byte from the serial receiver |
| rx_valid | input | 1 | `rx_byte` is offered this cycle |
| rx_ready | output | 1 | Queue can accept a byte this cycle |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle pulse: `tx_byte` is new |
| irq | output | 1 | Level receive interrupt |

## Verification
On every cycle the bound assertions check several things. The interrupt level must match the enable bit and the queue occupancy. `rx_ready` must track a full queue, the occupancy must never pass eight, and a refused byte must leave the occupancy unchanged. Each transmit write must yield exactly one strobe carrying the written byte. An empty receive read must return the flag word, and read data must hold between reads. Other behaviour can only be shown by the bench's scenarios against its queue-based model. That covers the first-in first-out order of the data itself and the full 32-bit storage of the control words. It also covers the silence of unmapped and misaligned offsets and the outcome of a push and pop in the same cycle at an empty or a full queue.

// File: rtl/urf_pkg.sv
package urf_pkg;

  // Register slot index taken from byte offset bits 4:2.
  typedef enum logic [2:0] {
    SLOT_TXDATA  = 3'd0,
    SLOT_RXDATA  = 3'd1,
    SLOT_TXCTRL  = 3'd2,
    SLOT_RXCTRL  = 3'd3,
    SLOT_IRQEN   = 3'd4,
    SLOT_IRQPEND = 3'd5,
    SLOT_BAUDDIV = 3'd6,
    SLOT_NONE    = 3'd7
  } slot_e;

  // Index of each stored word inside the control bank.
  localparam int BANK_TXCTRL  = 0;
  localparam int BANK_RXCTRL  = 1;
  localparam int BANK_IRQEN   = 2;
  localparam int BANK_BAUDDIV = 3;
  localparam int BANK_WORDS   = 4;

  // Bit positions with meaning to software.
  localparam int IRQEN_RX_BIT = 1;
  localparam int PEND_RX_BIT  = 1;

  // Byte offsets covered by one window.
  localparam int WINDOW_BITS = 5;

endpackage

// File: rtl/urf_addr_decode.sv
module urf_addr_decode #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output urf_pkg::slot_e    slot
);
  import urf_pkg::*;

  logic aligned;
  logic in_window;

  assign aligned = (addr[1:0] == 2'b00);

  generate
    if (ADDR_W > WINDOW_BITS) begin : g_upper
      assign in_window = (addr[ADDR_W-1:WINDOW_BITS] == '0);
    end else begin : g_exact
      assign in_window = 1'b1;
    end
  endgenerate

  always_comb begin
    if (aligned && in_window) begin
      slot = slot_e'(addr[4:2]);
    end else begin
      slot = SLOT_NONE;
    end
  end

endmodule

// File: rtl/urf_ctrl_bank.sv
module urf_ctrl_bank #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NWORDS-1:0]              wr_en,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NWORDS-1:0][DATA_W-1:0]  words
);

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          words[g] <= '0;
        end else if (wr_en[g]) begin
          words[g] <= wdata;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              push_ok;
  logic              pop_ok;

  // Acceptance is judged on the occupancy before the edge.
  assign push_ok = push && (count != FULL_CNT);
  assign pop_ok  = pop  && (count != '0);

  always_comb begin
    count_next = count;
    if (push_ok && !pop_ok) begin
      count_next = count + CNT_W'(1);
    end else if (pop_ok && !push_ok) begin
      count_next = count - CNT_W'(1);
    end
  end

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= din;
    end
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) begin
        wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
      end
      if (pop_ok) begin
        rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
      end
      count <= count_next;
    end
  end

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_strobe,
  output logic              irq
);
  import urf_pkg::*;

  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0]  FULL_CNT   = CNT_W'(RX_DEPTH);
  localparam logic [DATA_W-1:0] EMPTY_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  slot_e                              slot;
  logic [BANK_WORDS-1:0]              bank_wr;
  logic [BANK_WORDS-1:0][DATA_W-1:0]  bank;
  logic [BYTE_W-1:0]                  rx_head;
  logic [CNT_W-1:0]                   rx_count;
  logic [CNT_W-1:0]                   rx_count_next;
  logic                               rx_pop;
  logic                               rx_irq_en;
  logic                               rx_irq_en_next;
  logic                               tx_fire;
  logic [DATA_W-1:0]                  rd_mux;

  urf_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .slot (slot)
  );

  // One write enable per stored word.
  always_comb begin
    bank_wr = '0;
    if (bus_wr) begin
      unique case (slot)
        SLOT_TXCTRL:  bank_wr[BANK_TXCTRL]  = 1'b1;
        SLOT_RXCTRL:  bank_wr[BANK_RXCTRL]  = 1'b1;
        SLOT_IRQEN:   bank_wr[BANK_IRQEN]   = 1'b1;
        SLOT_BAUDDIV: bank_wr[BANK_BAUDDIV] = 1'b1;
        default:      bank_wr = '0;
      endcase
    end
  end

  urf_ctrl_bank #(.DATA_W(DATA_W), .NWORDS(BANK_WORDS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bank_wr),
    .wdata (bus_wdata),
    .words (bank)
  );

  assign rx_pop = bus_rd && (slot == SLOT_RXDATA);

  urf_rx_fifo #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) u_rxq (
    .clk        (clk),
    .rst        (rst),
    .push       (rx_valid),
    .din        (rx_byte),
    .pop        (rx_pop),
    .head       (rx_head),
    .count      (rx_count),
    .count_next (rx_count_next)
  );

  // Read multiplexer over the state before the edge.
  always_comb begin
    rd_mux = '0;
    unique case (slot)
      SLOT_RXDATA:  rd_mux = (rx_count != '0) ? DATA_W'(rx_head) : EMPTY_WORD;
      SLOT_TXCTRL:  rd_mux = bank[BANK_TXCTRL];
      SLOT_RXCTRL:  rd_mux = bank[BANK_RXCTRL];
      SLOT_IRQEN:   rd_mux = bank[BANK_IRQEN];
      SLOT_IRQPEND: rd_mux[PEND_RX_BIT] = (rx_count != '0);
      SLOT_BAUDDIV: rd_mux = bank[BANK_BAUDDIV];
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign tx_fire = bus_wr && (slot == SLOT_TXDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= tx_fire;
      if (tx_fire) begin
        tx_byte <= bus_wdata[BYTE_W-1:0];
      end
    end
  end

  // Interrupt and ready are registered from next state, so they match the
  // queue and enable word as they stand after each edge.
  assign rx_irq_en      = bank[BANK_IRQEN][IRQEN_RX_BIT];
  assign rx_irq_en_next = bank_wr[BANK_IRQEN] ? bus_wdata[IRQEN_RX_BIT] : rx_irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      rx_ready <= 1'b1;
    end else begin
      irq      <= rx_irq_en_next && (rx_count_next != '0);
      rx_ready <= (rx_count_next != FULL_CNT);
    end
  end

endmodule

// File: rtl/urf_checker.sv
module urf_checker #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8,
  parameter int CNT_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] wr_byte,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_strobe,
  input logic              irq,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              rxwm_en
);

  localparam logic [ADDR_W-1:0] OFS_TX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_RX = ADDR_W'(4);
  localparam logic [DATA_W-1:0] EMPTY_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(RX_DEPTH)); // R5

  AST_READY_TRACKS_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_ready == (fifo_count != CNT_W'(RX_DEPTH))); // R5

  AST_REFUSED_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !(bus_rd && bus_addr == OFS_RX)) |=> $stable(fifo_count)); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (rxwm_en && fifo_count != '0)); // R8

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_TX) |=> (tx_strobe && tx_byte == $past(wr_byte))); // R2

  AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(bus_wr && bus_addr == OFS_TX)); // R2

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_RX && fifo_count == '0) |=> bus_rdata == EMPTY_WORD); // R4

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_RX && fifo_count != '0 && !(rx_valid && rx_ready))
      |=> ($past(fifo_count) - fifo_count) == CNT_W'(1)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind uart_reg_front urf_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BYTE_W   (BYTE_W),
  .RX_DEPTH (RX_DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .wr_byte    (bus_wdata[BYTE_W-1:0]),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_byte    (tx_byte),
  .tx_strobe  (tx_strobe),
  .irq        (irq),
  .fifo_count (rx_count),
  .rxwm_en    (rx_irq_en)
);

// File: tb/tb_uart_reg_front.sv
`timescale 1ns/1ps
module tb_uart_reg_front;

  localparam int DEPTH = 8;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        irq;

  always #10 clk = ~clk;

  uart_reg_front dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
  );

  // Reference model.
  logic [7:0]  m_q[$];
  logic [31:0] m_txc, m_rxc, m_ie, m_div, m_rdata;
  logic        m_txs;
  logic [7:0]  m_txb;
  string       rd_tag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [4:0] a);
    case (a)
      5'h00: return 32'h0;
      5'h04: return (m_q.size() > 0) ? {24'h0, m_q[0]} : 32'h8000_0000;
      5'h08: return m_txc;
      5'h0C: return m_rxc;
      5'h10: return m_ie;
      5'h14: return (m_q.size() > 0) ? 32'h2 : 32'h0;
      5'h18: return m_div;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h04: return (m_q.size() > 0) ? "R3" : "R4";
      5'h08, 5'h0C, 5'h10, 5'h18: return "R6";
      5'h14: return "R7";
      default: return "R9";
    endcase
  endfunction

  // One clock: model the edge, then compare every output at the negedge.
  task automatic tick();
    int  sz = m_q.size();
    bit  pop_ok  = bus_rd && bus_addr == 5'h04 && sz > 0;
    bit  push_ok = rx_valid && sz < DEPTH;
    if (bus_rd) begin
      m_rdata = model_read(bus_addr);
      rd_tag  = tag_of(bus_addr);
    end else begin
      rd_tag = "R10";
    end
    m_txs = bus_wr && bus_addr == 5'h00;
    if (m_txs) m_txb = bus_wdata[7:0];
    if (bus_wr) begin
      case (bus_addr)
        5'h08: m_txc = bus_wdata;
        5'h0C: m_rxc = bus_wdata;
        5'h10: m_ie  = bus_wdata;
        5'h18: m_div = bus_wdata;
        default: ;
      endcase
    end
    if (pop_ok)  void'(m_q.pop_front());
    if (push_ok) m_q.push_back(rx_byte);
    @(negedge clk);
    chk(rd_tag, bus_rdata, m_rdata);
    chk("R2", {31'h0, tx_strobe}, {31'h0, m_txs});
    chk("R2", {24'h0, tx_byte}, {24'h0, m_txb});
    chk("R5", {31'h0, rx_ready}, {31'h0, (m_q.size() < DEPTH)});
    chk("R8", {31'h0, irq}, {31'h0, (m_ie[1] && m_q.size() > 0)});
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick();
  endtask

  task automatic push(logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1; tick();
  endtask

  task automatic rd_expect(logic [4:0] a, string tag, logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1; tick();
    chk(tag, bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_txc = '0; m_rxc = '0; m_ie = '0; m_div = '0; m_rdata = '0;
    m_txs = 1'b0; m_txb = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held.
    chk("R1", bus_rdata, 32'h0);
    chk("R1", {31'h0, tx_strobe}, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", {31'h0, rx_ready}, 32'h1);
    rst = 1'b0;
    rd_expect(5'h08, "R1", 32'h0);
    rd_expect(5'h10, "R1", 32'h0);
    rd_expect(5'h18, "R1", 32'h0);
    rd_expect(5'h04, "R1", 32'h8000_0000);

    // R2: transmit byte and transmit slot reads zero.
    wr(5'h00, 32'hDEAD_01A5);
    chk("R2", {24'h0, tx_byte}, 32'hA5);
    rd_expect(5'h00, "R2", 32'h0);

    // R6: full-width storage.
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h1234_5678);
    wr(5'h18, 32'h8000_0001);
    wr(5'h10, 32'hA5A5_A5A4);
    rd_expect(5'h08, "R6", 32'hFFFF_FFFF);
    rd_expect(5'h0C, "R6", 32'h1234_5678);
    rd_expect(5'h18, "R6", 32'h8000_0001);
    rd_expect(5'h10, "R6", 32'hA5A5_A5A4);
    wr(5'h10, 32'h0);

    // R4 / R7: empty queue.
    rd_expect(5'h04, "R4", 32'h8000_0000);
    rd_expect(5'h14, "R7", 32'h0);

    // R8 / R7: interrupt gating.
    push(8'h11); push(8'h22); push(8'h33);
    chk("R8", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h1);
    chk("R8", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h2);
    chk("R8", {31'h0, irq}, 32'h1);
    wr(5'h14, 32'hFFFF_FFFF);
    rd_expect(5'h14, "R7", 32'h2);

    // R3: order and removal.
    rd_expect(5'h04, "R3", 32'h11);
    rd_expect(5'h04, "R3", 32'h22);
    rd_expect(5'h04, "R3", 32'h33);
    chk("R8", {31'h0, irq}, 32'h0);
    rd_expect(5'h04, "R4", 32'h8000_0000);

    // R5: fill past capacity.
    for (int i = 0; i < 10; i++) push(8'h40 + 8'(i));
    chk("R5", {31'h0, rx_ready}, 32'h0);
    for (int i = 0; i < 8; i++) rd_expect(5'h04, "R5", 32'h40 + i);
    rd_expect(5'h04, "R5", 32'h8000_0000);

    // R11: push and pop together, then at a full queue.
    push(8'h77);
    bus_addr = 5'h04; bus_rd = 1'b1; rx_byte = 8'h88; rx_valid = 1'b1; tick();
    chk("R11", bus_rdata, 32'h77);
    rd_expect(5'h04, "R11", 32'h88);
    bus_addr = 5'h04; bus_rd = 1'b1; rx_byte = 8'h99; rx_valid = 1'b1; tick();
    chk("R11", bus_rdata, 32'h8000_0000);
    rd_expect(5'h04, "R11", 32'h99);
    for (int i = 0; i < 8; i++) push(8'hC0 + 8'(i));
    bus_addr = 5'h04; bus_rd = 1'b1; rx_byte = 8'hEE; rx_valid = 1'b1; tick();
    chk("R11", bus_rdata, 32'hC0);
    for (int i = 1; i < 8; i++) rd_expect(5'h04, "R11", 32'hC0 + i);
    rd_expect(5'h04, "R11", 32'h8000_0000);

    // R9: unmapped and misaligned offsets.
    wr(5'h1C, 32'h5555_5555);
    wr(5'h09, 32'h0000_0000);
    wr(5'h01, 32'h0000_00FF);
    chk("R9", {31'h0, tx_strobe}, 32'h0);
    rd_expect(5'h1C, "R9", 32'h0);
    rd_expect(5'h0A, "R9", 32'h0);
    rd_expect(5'h08, "R9", 32'hFFFF_FFFF);

    // R10: idle cycles hold read data.
    repeat (4) tick();

    // Mixed traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom % 10;
      case (sel)
        0: bus_addr = 5'h00; 1: bus_addr = 5'h04; 2: bus_addr = 5'h04;
        3: bus_addr = 5'h08; 4: bus_addr = 5'h0C; 5: bus_addr = 5'h10;
        6: bus_addr = 5'h14; 7: bus_addr = 5'h18; 8: bus_addr = 5'h1C;
        default: bus_addr = 5'h0D;
      endcase
      bus_wdata = $urandom;
      bus_rd    = ($urandom % 2) == 0;
      bus_wr    = ($urandom % 4) == 0;
      rx_byte   = 8'($urandom);
      rx_valid  = ($urandom % 3) != 0;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule